// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This block executes the eight integer multiply, divide and remainder operations of a 32-bit processor's register-register group. The caller has already recognised the request as one of these operations. It presents two source operands and the three-bit operation selector, then pulses `start`. The unit then runs for a fixed number of cycles and returns one 32-bit result.

Products are formed by a shift-add loop that consumes one multiplier bit per cycle into a double-width accumulator. Quotients and remainders are formed by a restoring loop that settles one quotient bit per cycle. Signed operations run on operand magnitudes, and a final step restores the signs. The same loop registers serve both kinds of operation. Selecting the writeback register and decoding the wider opcode fields are left to the surrounding pipeline.

Top module: `muldiv_iter`

## Requirements
- R1: After reset `busy` and `done` are low and `result` is zero.
- R2: A `start` seen while idle raises `busy` on the next cycle. `done` is high for exactly one cycle, 34 clock edges after the accepting edge (counting that edge), with `result` valid in that cycle. `busy` falls on the cycle after `done`.
- R3: While `busy` is high, `start` and any change of `opA`, `opB` or `funct3` have no effect on the result being computed.
- R4: `funct3` = 000 returns the low 32 bits of `opA` × `opB`.
- R5: `funct3` = 001 returns the upper 32 bits of the 64-bit product with both operands taken as two's complement.
- R6: `funct3` = 010 returns the upper 32 bits of the product of a signed `opA` and an unsigned `opB`.
- R7: `funct3` = 011 returns the upper 32 bits of the product with both operands unsigned.
- R8: `funct3` = 100 returns the signed quotient `opA` / `opB`, rounded toward zero.
- R9: `funct3` = 101 returns the unsigned quotient.
- R10: `funct3` = 110 returns the signed remainder, which carries the sign of `opA`. `funct3` = 111 returns the unsigned remainder.
- R11: For a divisor of zero, the quotient (100, 101) is all ones and the remainder (110, 111) equals `opA`.
- R12: For `opA` = 0x80000000 and `opB` = 0xFFFFFFFF, signed division returns 0x80000000 and the signed remainder returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only while idle |
| funct3 | input | 3 | Operation selector |
| opA | input | 32 | First source operand (multiplicand / dividend) |
| opB | input | 32 | Second source operand (multiplier / divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result, valid while `done` is high |

## Verification
Random operand pairs go through every selector. They split the cases where the operand signs agree from those where they differ, so a missing or misplaced sign fix-up in the high-product and quotient paths shows up. Directed pairs hit the extremes: zero, ±1, the most negative value and all ones. These catch confusion between the three high-half signedness modes and rounding errors in the remainder. Zero divisors and the most-negative-by-minus-one case test the required fixed results. A run that re-asserts `start` with new operands mid-operation tells a unit that ignores it apart from one that restarts or re-samples.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } mdState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture operands and selector
    logic step;    // one multiply or divide iteration
    logic finish;  // sign fix-up and result capture
  } mdStrobe_t;

  localparam logic [2:0] F3_MUL    = 3'b000;
  localparam logic [2:0] F3_MULH   = 3'b001;
  localparam logic [2:0] F3_MULHSU = 3'b010;
  localparam logic [2:0] F3_MULHU  = 3'b011;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output mdStrobe_t strobe,
  output logic      busy,
  output logic      done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mdState_e stateQ, stateD;
  logic [CW-1:0] stepCntQ;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: if (start) begin
        strobe.load = 1'b1;
        stateD = ST_RUN;
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (stepCntQ == LAST) stateD = ST_FIX;
      end
      ST_FIX: begin
        strobe.finish = 1'b1;
        stateD = ST_DONE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      stepCntQ <= '0;
    end else begin
      stateQ <= stateD;
      if (strobe.load)      stepCntQ <= '0;
      else if (strobe.step) stepCntQ <= stepCntQ + 1'b1;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = (stateQ == ST_DONE);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic [2:0]   funct3,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] result
);
  localparam int PW = 2 * W;

  logic [2:0]   f3Q;
  logic         negMainQ;   // negate product or quotient
  logic         negRemQ;    // negate remainder
  logic [W-1:0] magBQ;      // multiplicand or divisor magnitude
  logic [W:0]   accHiQ;     // upper product half / partial remainder
  logic [W-1:0] accLoQ;     // multiplier bits / quotient bits
  logic [W-1:0] resQ;

  // operand conditioning at load
  logic isDiv, sgnA, sgnB, aNeg, bNeg, bZero, negProd;
  logic [W-1:0] magA, magB;

  always_comb begin
    isDiv = funct3[2];
    aNeg  = opA[W-1];
    bNeg  = opB[W-1];
    bZero = (opB == '0);
    if (isDiv) begin
      sgnA = ~funct3[0];
      sgnB = ~funct3[0];
    end else begin
      sgnA = (funct3 == F3_MULH) || (funct3 == F3_MULHSU);
      sgnB = (funct3 == F3_MULH);
    end
    magA    = (sgnA && aNeg) ? (~opA + 1'b1) : opA;
    magB    = (sgnB && bNeg) ? (~opB + 1'b1) : opB;
    negProd = (sgnA && aNeg) ^ (sgnB && bNeg);
  end

  // one multiply iteration
  logic [W:0] mulAddend, mulSum;
  always_comb begin
    mulAddend = accLoQ[0] ? {1'b0, magBQ} : '0;
    mulSum    = accHiQ + mulAddend;
  end

  // one restoring-divide iteration
  logic [W:0]   remShift;
  logic [W+1:0] trial;
  logic         borrow;
  always_comb begin
    remShift = {accHiQ[W-1:0], accLoQ[W-1]};
    trial    = {1'b0, remShift} - {2'b00, magBQ};
    borrow   = trial[W+1];
  end

  // sign fix-up and selection
  logic [PW-1:0] prodRaw, prodFix;
  logic [W-1:0]  quoFix, remFix, resD;
  always_comb begin
    prodRaw = {accHiQ[W-1:0], accLoQ};
    prodFix = negMainQ ? (~prodRaw + 1'b1) : prodRaw;
    quoFix  = negMainQ ? (~accLoQ + 1'b1) : accLoQ;
    remFix  = negRemQ ? (~accHiQ[W-1:0] + 1'b1) : accHiQ[W-1:0];
    if (f3Q[2])               resD = f3Q[1] ? remFix : quoFix;
    else if (f3Q == F3_MUL)   resD = prodFix[W-1:0];
    else                      resD = prodFix[PW-1:W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      f3Q      <= '0;
      negMainQ <= 1'b0;
      negRemQ  <= 1'b0;
      magBQ    <= '0;
      accHiQ   <= '0;
      accLoQ   <= '0;
      resQ     <= '0;
    end else begin
      if (strobe.load) begin
        f3Q      <= funct3;
        negMainQ <= isDiv ? (negProd && !bZero) : negProd;
        negRemQ  <= sgnA && aNeg;
        magBQ    <= magB;
        accHiQ   <= '0;
        accLoQ   <= magA;
      end else if (strobe.step) begin
        if (f3Q[2]) begin
          accHiQ <= borrow ? remShift : trial[W:0];
          accLoQ <= {accLoQ[W-2:0], ~borrow};
        end else begin
          accHiQ <= {1'b0, mulSum[W:1]};
          accLoQ <= {mulSum[0], accLoQ[W-1:1]};
        end
      end
      if (strobe.finish) resQ <= resD;
    end
  end

  assign result = resQ;

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   funct3,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  mdStrobe_t strobe;

  muldiv_ctrl #(.W(W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  muldiv_dp #(.W(W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .funct3 (funct3),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: rtl/muldiv_iter_chk.sv
module muldiv_iter_chk #(
  parameter int W = 32
) (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int LAT = W + 2;
  localparam int KW  = $clog2(LAT + 2) + 1;

  logic [KW-1:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               sinceStart <= '0;
    else if (start && !busy) sinceStart <= KW'(1);
    else if (busy)           sinceStart <= sinceStart + 1'b1;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R2
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R2
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN) done |=> !busy); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN) $rose(busy) |-> $past(start)); // R2
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN) done |-> (sinceStart == KW'(LAT))); // R2
  AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN) (busy && !done) |=> busy); // R3

endmodule

bind muldiv_iter muldiv_iter_chk #(.W(W)) uChk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/tb_muldiv_iter.sv
module tb_muldiv_iter;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 34;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] funct3 = '0;
  logic [31:0] opA = '0, opB = '0;
  logic busy, done;
  logic [31:0] result;

  int nTests = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  muldiv_iter dut (
    .clk(clk), .rstN(rstN), .start(start), .funct3(funct3),
    .opA(opA), .opB(opB), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] refCalc(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub;
    logic [63:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    case (f)
      3'b000: begin p = 64'(ua * ub); return p[31:0]; end
      3'b001: begin p = 64'(sa * sb); return p[63:32]; end
      3'b010: begin p = 64'(sa * ub); return p[63:32]; end
      3'b011: begin p = 64'(ua) * 64'(ub); return p[63:32]; end
      3'b100: begin
        if (b == 0) return 32'hFFFF_FFFF;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return 32'($signed(a) / $signed(b));
      end
      3'b101: return (b == 0) ? 32'hFFFF_FFFF : a / b;
      3'b110: begin
        if (b == 0) return a;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
        return 32'($signed(a) % $signed(b));
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    if (f[2] && b == 0) return "R11";
    if (f[2] && !f[0] && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return "R12";
    case (f)
      3'b000: return "R4";
      3'b001: return "R5";
      3'b010: return "R6";
      3'b011: return "R7";
      3'b100: return "R8";
      3'b101: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // run one operation; if disturb is set, start is re-asserted with other operands mid-run
  task automatic runOp(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b, input bit disturb);
    logic [31:0] exp;
    int edges;
    exp = refCalc(f, a, b);
    @(negedge clk);
    funct3 = f; opA = a; opB = b; start = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    start = 1'b0;
    check("R2", "busy after accept", {31'b0, busy}, 32'd1);
    if (disturb) begin
      funct3 = ~f; opA = ~a; opB = b + 32'd3; start = 1'b1;
    end
    while (!done && edges < LAT + 4) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (edges == 5) start = 1'b0;
    end
    start = 1'b0;
    check("R2", "done latency", 32'(edges), 32'(LAT));
    check(disturb ? "R3" : tagFor(f, a, b), "result", result, exp);
    @(posedge clk);
    @(negedge clk);
    check("R2", "done width / busy release", {30'b0, done, busy}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nTests++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [8];
    void'($urandom(32'd2024));
    corners[0] = 32'h0;        corners[1] = 32'h1;
    corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h0000_0007;
    corners[6] = 32'hFFFF_FFF9; corners[7] = 32'h0001_0000;

    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {busy, done, 30'b0} | result, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {30'b0, busy, done}, 32'd0);

    // directed corners over every selector
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j += 3)
          runOp(3'(f), corners[i], corners[j], 1'b0);

    // explicit special results
    runOp(3'b100, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R12
    runOp(3'b110, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0); // R12
    runOp(3'b100, 32'hFFFF_FF85, 32'h0, 1'b0);         // R11
    runOp(3'b111, 32'h1234_5678, 32'h0, 1'b0);         // R11
    runOp(3'b110, 32'hFFFF_FFF9, 32'h2, 1'b0);         // R10 remainder takes dividend sign

    // start while busy must be ignored
    runOp(3'b001, 32'hDEAD_BEEF, 32'h1357_9BDF, 1'b1); // R3
    runOp(3'b100, 32'hF000_0001, 32'h0000_0013, 1'b1); // R3

    // random
    for (int n = 0; n < 30; n++)
      for (int f = 0; f < 8; f++)
        runOp(3'(f), $urandom, ($urandom & 1) ? $urandom : ($urandom & 32'hFF), 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule